// File: doc/BRIEF.md
# Multi-Queue Interprocessor Mailbox

This block lets several processors pass 32-bit messages to each other through a set of small hardware queues reached over a simple 32-bit register bus. A sender writes a word to a queue's message register and the word joins that queue. A receiver reads the same register and takes the oldest word out. Each queue also has a full flag and a fill count, so software can poll it without side effects.

Every queue produces two interrupt events. A new-message event fires on each accepted push. A not-full event fires when a pop frees space in a queue that was full. Each processor user has its own status and enable registers, which cover the events of all queues, and drives one interrupt line. Status bits are cleared by writing 1 to them.

A parameter picks one of two address layouts for the per-user registers. The newer layout adds a register that clears enable bits by writing 1 to them. Read data is combinational in the cycle that the read strobe is high. The pop, if any, takes effect at the next clock edge.

Top module: `mbox_ipc`

## Requirements
- R1: A read of offset 0x000 returns the revision: zero in bits [31:8], the major number in bits [7:4] and the minor number in bits [3:0].
- R2: A write to offset 0x040+4*m appends the data to queue m. A read of that offset returns the oldest entry of queue m and removes it. Words leave in arrival order, and each queue is independent of the others.
- R3: A queue holds DEPTH entries (default 4). A write to a full queue is dropped. The word at offset 0x080+4*m reads 1 when queue m holds DEPTH entries and reads 0 otherwise.
- R4: The word at offset 0x0C0+4*m reads the number of entries in queue m, which is zero exactly when the queue is empty. A read of an empty queue's message register returns 0 and leaves the count at 0.
- R5: In every user's status register, bit 2*m sets on each accepted push into queue m, and bit 2*m+1 sets when a pop takes queue m from full to not full.
- R6: A status bit is cleared by writing 1 to it. A status bit written with 0 keeps its value. An event in the same cycle as a clear takes priority over the clear.
- R7: With the older layout, user u's status register is at 0x100+8*u and its enable register is at 0x104+8*u. A write replaces the enable value, and a read returns it.
- R8: With the newer layout, user u's status register is at 0x104+0x10*u, its enable register is at 0x108+0x10*u and its enable-clear register is at 0x10C+0x10*u. Writing 1 to a bit of the enable-clear register clears the matching enable bit and leaves the other enable bits unchanged.
- R9: The interrupt line of user u is high exactly when some bit is set in both u's status register and u's enable register.
- R10: Status and enable bits at or above position 2*NQ read 0, and writes to them have no effect. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; pops the queue when it addresses a message register |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irq_out | output | NU | One interrupt line per user |

## Verification
The bench sweeps every queue in both layouts. For each queue it pushes one word more than the queue holds, and it checks the fill count and the full flag after every write. A design that accepted the extra word would show a count of five or return it on a later pop. A design with an off-by-one full test would raise the flag too early.

The not-full event is checked on the first pop from a full queue. A design that set it on every pop, or set the new-message bit instead, would show the wrong status word. The bench also reads an empty queue, and a design that popped stale storage would return a nonzero word or underflow the count.

On the interrupt side, the bench checks that zero writes leave status unchanged. It also checks that the enable-clear register removes only the bits written as 1, and that a user without the matching enable keeps its line low while another user's line rises.

// File: rtl/mbox_ipc_pkg.sv
package mbox_ipc_pkg;

   localparam int unsigned WORD_W   = 32;

   // Fixed region bases (byte offsets)
   localparam int unsigned OFS_REV  = 32'h000;
   localparam int unsigned OFS_MSG  = 32'h040;
   localparam int unsigned OFS_FULL = 32'h080;
   localparam int unsigned OFS_CNT  = 32'h0C0;

   // Per-user register placement for the two layouts
   localparam int unsigned OLD_STAT_BASE = 32'h100;
   localparam int unsigned OLD_EN_BASE   = 32'h104;
   localparam int unsigned OLD_STRIDE    = 8;
   localparam int unsigned NEW_STAT_BASE = 32'h104;
   localparam int unsigned NEW_EN_BASE   = 32'h108;
   localparam int unsigned NEW_CLR_BASE  = 32'h10C;
   localparam int unsigned NEW_STRIDE    = 16;

   // Window sizes in bytes
   localparam int unsigned OLD_WINDOW = 32'h120;
   localparam int unsigned NEW_WINDOW = 32'h130;

endpackage

// File: rtl/mbox_queue.sv
module mbox_queue #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [DW-1:0]    din,
   output logic [DW-1:0]    head,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);

   logic [DW-1:0]    store [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] cnt_q;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign empty = (cnt_q == '0);
   assign count = cnt_q;
   assign head  = store[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) wr_ptr <= step(wr_ptr);
         if (pop)  rd_ptr <= step(rd_ptr);
         if (push && !pop)      cnt_q <= cnt_q + 1'b1;
         else if (pop && !push) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) store[wr_ptr] <= din;
   end

endmodule

// File: rtl/mbox_user_irq.sv
module mbox_user_irq #(
   parameter int unsigned EV_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [EV_W-1:0] set_ev,
   input  logic            wr_stat,
   input  logic            wr_en,
   input  logic            wr_clr,
   input  logic [EV_W-1:0] wdata,
   output logic [EV_W-1:0] stat,
   output logic [EV_W-1:0] en,
   output logic            irq
);

   logic [EV_W-1:0] clr_mask;

   assign clr_mask = wr_stat ? wdata : '0;
   assign irq      = |(stat & en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         en   <= '0;
      end else begin
         // events win over a simultaneous write-1-to-clear
         stat <= (stat & ~clr_mask) | set_ev;
         if (wr_en)       en <= wdata;
         else if (wr_clr) en <= en & ~wdata;
      end
   end

endmodule

// File: rtl/mbox_ipc.sv
module mbox_ipc
   import mbox_ipc_pkg::*;
#(
   parameter int unsigned NQ         = 4,
   parameter int unsigned NU         = 3,
   parameter int unsigned DEPTH      = 4,
   parameter bit          NEW_LAYOUT = 1'b0,
   parameter int unsigned ADDR_W     = 9,
   parameter logic [3:0]  REV_MAJOR  = 4'd2,
   parameter logic [3:0]  REV_MINOR  = 4'd0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   output logic [NU-1:0]     irq_out
);

   localparam int unsigned EV_W   = 2 * NQ;
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
   localparam int unsigned WINDOW = NEW_LAYOUT ? NEW_WINDOW : OLD_WINDOW;
   localparam int unsigned LAST_U = NEW_LAYOUT ? (NEW_CLR_BASE + NEW_STRIDE * (NU - 1) + 4)
                                               : (OLD_EN_BASE + OLD_STRIDE * (NU - 1) + 4);

   // ---------------- elaboration checks ----------------
   if (NQ < 1 || NQ > 16)          begin : g_bad_nq    $error("NQ must be 1..16"); end
   if (NU < 1 || LAST_U > WINDOW)  begin : g_bad_nu    $error("NU does not fit the register window"); end
   if (DEPTH < 2)                  begin : g_bad_depth $error("DEPTH must be at least 2"); end
   if ((1 << ADDR_W) < WINDOW)     begin : g_bad_aw    $error("ADDR_W too narrow for the window"); end

   // ---------------- queue side ----------------
   logic [NQ-1:0]     sel_msg, sel_full, sel_cnt;
   logic [NQ-1:0]     wr_msg, push, pop, q_full, q_empty;
   logic [WORD_W-1:0] q_head [NQ];
   logic [CNT_W-1:0]  q_cnt  [NQ];
   logic [NQ*CNT_W-1:0] q_cnt_flat;
   logic [EV_W-1:0]   ev;

   for (genvar m = 0; m < NQ; m++) begin : g_q
      assign sel_msg[m]  = (bus_addr == ADDR_W'(OFS_MSG  + 4 * m));
      assign sel_full[m] = (bus_addr == ADDR_W'(OFS_FULL + 4 * m));
      assign sel_cnt[m]  = (bus_addr == ADDR_W'(OFS_CNT  + 4 * m));

      assign wr_msg[m] = bus_wr & sel_msg[m];
      assign push[m]   = wr_msg[m] & ~q_full[m];
      assign pop[m]    = bus_rd & sel_msg[m] & ~q_empty[m];

      mbox_queue #(.DW(WORD_W), .DEPTH(DEPTH)) u_queue (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (push[m]),
         .pop   (pop[m]),
         .din   (bus_wdata),
         .head  (q_head[m]),
         .count (q_cnt[m]),
         .full  (q_full[m]),
         .empty (q_empty[m])
      );

      assign ev[2*m]     = push[m];
      assign ev[2*m + 1] = pop[m] & q_full[m];
      assign q_cnt_flat[m*CNT_W +: CNT_W] = q_cnt[m];
   end

   // ---------------- user side ----------------
   logic [NU-1:0]      sel_stat, sel_en, sel_clr;
   logic [NU-1:0]      wr_stat, wr_en, wr_clr;
   logic [EV_W-1:0]    u_stat [NU];
   logic [EV_W-1:0]    u_en   [NU];
   logic [NU*EV_W-1:0] stat_flat, en_flat;

   for (genvar u = 0; u < NU; u++) begin : g_u
      if (NEW_LAYOUT) begin : g_new
         assign sel_stat[u] = (bus_addr == ADDR_W'(NEW_STAT_BASE + NEW_STRIDE * u));
         assign sel_en[u]   = (bus_addr == ADDR_W'(NEW_EN_BASE   + NEW_STRIDE * u));
         assign sel_clr[u]  = (bus_addr == ADDR_W'(NEW_CLR_BASE  + NEW_STRIDE * u));
      end else begin : g_old
         assign sel_stat[u] = (bus_addr == ADDR_W'(OLD_STAT_BASE + OLD_STRIDE * u));
         assign sel_en[u]   = (bus_addr == ADDR_W'(OLD_EN_BASE   + OLD_STRIDE * u));
         assign sel_clr[u]  = 1'b0;
      end

      assign wr_stat[u] = bus_wr & sel_stat[u];
      assign wr_en[u]   = bus_wr & sel_en[u];
      assign wr_clr[u]  = bus_wr & sel_clr[u];

      mbox_user_irq #(.EV_W(EV_W)) u_irq (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_ev  (ev),
         .wr_stat (wr_stat[u]),
         .wr_en   (wr_en[u]),
         .wr_clr  (wr_clr[u]),
         .wdata   (bus_wdata[EV_W-1:0]),
         .stat    (u_stat[u]),
         .en      (u_en[u]),
         .irq     (irq_out[u])
      );

      assign stat_flat[u*EV_W +: EV_W] = u_stat[u];
      assign en_flat[u*EV_W +: EV_W]   = u_en[u];
   end

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (bus_addr == ADDR_W'(OFS_REV)) bus_rdata = {24'h0, REV_MAJOR, REV_MINOR};
         for (int m = 0; m < NQ; m++) begin
            if (sel_msg[m] && !q_empty[m]) bus_rdata = q_head[m];
            if (sel_full[m])               bus_rdata = 32'(q_full[m]);
            if (sel_cnt[m])                bus_rdata = 32'(q_cnt[m]);
         end
         for (int u = 0; u < NU; u++) begin
            if (sel_stat[u]) bus_rdata = 32'(u_stat[u]);
            if (sel_en[u])   bus_rdata = 32'(u_en[u]);
         end
      end
   end

endmodule

// File: rtl/mbox_ipc_chk.sv
module mbox_ipc_chk #(
   parameter int unsigned NQ    = 4,
   parameter int unsigned NU    = 3,
   parameter int unsigned DEPTH = 4,
   parameter int unsigned CNT_W = 3,
   localparam int unsigned EV_W = 2 * NQ
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NQ*CNT_W-1:0] q_cnt_flat,
   input logic [NQ-1:0]      q_full,
   input logic [NQ-1:0]      wr_msg,
   input logic [EV_W-1:0]    ev,
   input logic [NU-1:0]      wr_stat,
   input logic [EV_W-1:0]    wdata,
   input logic [NU*EV_W-1:0] stat_flat,
   input logic [NU*EV_W-1:0] en_flat,
   input logic [NU-1:0]      irq_out
);

   for (genvar m = 0; m < NQ; m++) begin : g_qc
      a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
         q_cnt_flat[m*CNT_W +: CNT_W] <= CNT_W'(DEPTH));
      a_r3_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
         q_full[m] == (q_cnt_flat[m*CNT_W +: CNT_W] == CNT_W'(DEPTH)));
      a_r3_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
         (q_full[m] && wr_msg[m]) |=> $stable(q_cnt_flat[m*CNT_W +: CNT_W]));
   end

   for (genvar u = 0; u < NU; u++) begin : g_uc
      a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out[u] == |(stat_flat[u*EV_W +: EV_W] & en_flat[u*EV_W +: EV_W]));
      for (genvar b = 0; b < EV_W; b++) begin : g_bc
         a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            ev[b] |=> stat_flat[u*EV_W + b]);
         a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stat[u] && wdata[b] && !ev[b]) |=> !stat_flat[u*EV_W + b]);
      end
   end

endmodule

bind mbox_ipc mbox_ipc_chk #(
   .NQ(NQ), .NU(NU), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .q_cnt_flat (q_cnt_flat),
   .q_full     (q_full),
   .wr_msg     (wr_msg),
   .ev         (ev),
   .wr_stat    (wr_stat),
   .wdata      (bus_wdata[2*NQ-1:0]),
   .stat_flat  (stat_flat),
   .en_flat    (en_flat),
   .irq_out    (irq_out)
);

// File: tb/mbox_ipc_tb_top.sv
module mbox_ipc_tb_top;

   localparam int CLK_P = 10;
   localparam int NQ = 4;
   localparam int NU = 3;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        wr0 = 1'b0, rd0 = 1'b0, wr1 = 1'b0, rd1 = 1'b0;
   logic [31:0] rdata0, rdata1;
   logic [NU-1:0] irq0, irq1;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   mbox_ipc #(.NQ(NQ), .NU(NU), .DEPTH(DEPTH), .NEW_LAYOUT(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr0), .bus_wdata(wdata),
      .bus_rd(rd0), .bus_rdata(rdata0), .irq_out(irq0));

   mbox_ipc #(.NQ(NQ), .NU(NU), .DEPTH(DEPTH), .NEW_LAYOUT(1'b1)) dut_n_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr1), .bus_wdata(wdata),
      .bus_rd(rd1), .bus_rdata(rdata1), .irq_out(irq1));

   function automatic int sa(int lay, int u); return lay ? 'h104 + 16*u : 'h100 + 8*u; endfunction
   function automatic int ea(int lay, int u); return lay ? 'h108 + 16*u : 'h104 + 8*u; endfunction
   function automatic int ca(int u);          return 'h10C + 16*u; endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bw(input int lay, input int a, input logic [31:0] d);
      @(negedge clk);
      addr = a[8:0]; wdata = d;
      if (lay == 0) wr0 = 1'b1; else wr1 = 1'b1;
      @(negedge clk);
      wr0 = 1'b0; wr1 = 1'b0;
   endtask

   task automatic br(input int lay, input int a, output logic [31:0] d);
      @(negedge clk);
      addr = a[8:0];
      if (lay == 0) rd0 = 1'b1; else rd1 = 1'b1;
      #1 d = (lay == 0) ? rdata0 : rdata1;
      @(negedge clk);
      rd0 = 1'b0; rd1 = 1'b0;
   endtask

   function automatic logic [31:0] irqs(int lay);
      return (lay == 0) ? 32'(irq0) : 32'(irq1);
   endfunction

   task automatic clear_all(input int lay);
      for (int u = 0; u < NU; u++) bw(lay, sa(lay, u), 32'hFFFF_FFFF);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int lay = 0; lay < 2; lay++) begin
         // reset state
         br(lay, 'h000, r); chk("R1 revision", r, 32'h0000_0020);
         for (int m = 0; m < NQ; m++) begin
            br(lay, 'h0C0 + 4*m, r); chk("R4 reset count", r, 0);
            br(lay, 'h080 + 4*m, r); chk("R3 reset full", r, 0);
         end
         chk("R9 reset irq", irqs(lay), 0);
         br(lay, sa(lay, 0), r); chk("R5 reset status", r, 0);

         // per-queue sweep
         for (int m = 0; m < NQ; m++) begin
            clear_all(lay);
            for (int k = 0; k <= DEPTH; k++) begin
               bw(lay, 'h040 + 4*m, 32'hA000_0000 | (m << 8) | k);
               br(lay, 'h0C0 + 4*m, r);
               chk("R3 R4 count after push", r, (k + 1 > DEPTH) ? DEPTH : k + 1);
               br(lay, 'h080 + 4*m, r);
               chk("R3 full flag", r, (k + 1 >= DEPTH) ? 1 : 0);
            end
            br(lay, 'h0C0 + 4*((m + 1) % NQ), r); chk("R2 other queue untouched", r, 0);
            for (int u = 0; u < NU; u++) begin
               br(lay, sa(lay, u), r); chk("R5 new-message bit", r, 32'(1) << (2*m));
            end
            clear_all(lay);
            for (int k = 0; k < DEPTH; k++) begin
               br(lay, 'h040 + 4*m, r);
               chk("R2 FIFO order", r, 32'hA000_0000 | (m << 8) | k);
               if (k == 0) begin
                  for (int u = 0; u < NU; u++) begin
                     br(lay, sa(lay, u), r); chk("R5 not-full bit", r, 32'(1) << (2*m + 1));
                  end
                  clear_all(lay);
               end
            end
            br(lay, sa(lay, 0), r); chk("R5 no not-full on later pops", r, 0);
            br(lay, 'h040 + 4*m, r); chk("R4 empty read", r, 0);
            br(lay, 'h0C0 + 4*m, r); chk("R4 empty count", r, 0);
         end

         // enables and interrupts
         clear_all(lay);
         bw(lay, ea(lay, 0), 32'h0000_0001);
         br(lay, ea(lay, 0), r); chk(lay ? "R8 enable readback" : "R7 enable readback", r, 1);
         bw(lay, 'h044, 32'h1);
         chk("R9 masked event no irq", irqs(lay), 0);
         bw(lay, 'h040, 32'h2);
         chk("R9 enabled event irq user0 only", irqs(lay), 1);
         bw(lay, sa(lay, 0), 32'h0);
         br(lay, sa(lay, 0), r); chk("R6 zero write keeps status", r, 32'h5);
         chk("R6 irq held", irqs(lay), 1);
         bw(lay, sa(lay, 0), 32'h1);
         br(lay, sa(lay, 0), r); chk("R6 w1c clears only bit0", r, 32'h4);
         chk("R9 irq drops after clear", irqs(lay), 0);
         bw(lay, sa(lay, 0), 32'hFFFF_FFFF);
         br(lay, sa(lay, 0), r); chk("R6 w1c all", r, 0);
         bw(lay, ea(lay, 1), 32'hFFFF_FFFF);
         br(lay, ea(lay, 1), r); chk("R10 enable upper bits", r, 32'hFF);
         if (lay == 0) begin
            bw(lay, ea(lay, 1), 32'h0000_0030);
            br(lay, ea(lay, 1), r); chk("R7 enable rewrite", r, 32'h30);
         end else begin
            bw(lay, ca(1), 32'h0000_000F);
            br(lay, ea(lay, 1), r); chk("R8 enable-clear", r, 32'hF0);
            br(lay, ea(lay, 0), r); chk("R8 other user unaffected", r, 1);
         end
         br(lay, 'h1F0, r); chk("R10 unmapped read", r, 0);
         br(lay, 'h040, r); chk("R2 drain q0", r, 2);
         br(lay, 'h044, r); chk("R2 drain q1", r, 1);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule